// File: doc/BRIEF.md
# DMA Page Translation Cache with Address-Space Tags

This block sits inside an I/O device, between the engine that issues DMA accesses and the link to the host. Each access presents a 48-bit untranslated address together with a 20-bit address-space identifier. The cache holds recent page mappings. When the page number and the identifier both match a stored entry, the block returns the translated address one clock later.

When a lookup misses, the block never forwards the untranslated address. It parks the lookup, stops accepting new ones, and sends a translation request for the page over an outbound valid/ready port. The answer comes back on a completion input. A successful answer is written into the cache and also returned to the requester. A failed answer raises a page request on a second outbound port. The block then waits for a page-present pulse and asks for the translation once more. If the second attempt also fails, the requester receives an error response.

Software or the link layer can drop a single mapping, selected by its identifier and page, or drop every mapping at once. Pages are 4 KiB, so the low 12 address bits pass through unchanged.

Top module: `dma_xlat_cache`

## Requirements
- R1: A lookup that misses produces no response in the following cycle. It raises `xlReqValid` carrying the lookup's identifier and page number (`lkAddr[47:12]`). `lkReady` stays low for as long as a translation request or page request is pending.
- R2: While `xlReqValid` is high and `xlReqReady` is low, `xlReqValid`, `xlReqSpace` and `xlReqPage` hold their values.
- R3: A completion with `xlDoneOk`=1 fills a cache entry. One cycle after the completion, `rspValid` is high, `rspErr` is 0 and `rspAddr` = {`xlDonePage`, lookup offset}.
- R4: A lookup that hits is answered in the cycle after it is accepted, with `rspErr`=0 and `rspAddr` = {stored translated page, `lkAddr[11:0]`}. No translation request is issued.
- R5: An entry hits only when both its 20-bit identifier and its 36-bit page number equal the lookup's. The same page under a different identifier misses.
- R6: A completion with `xlDoneOk`=0 on the first attempt raises `pgReqValid` with the same identifier and page, held stable until `pgReqReady`. No translation request is issued until a `pgPresent` pulse arrives. After that pulse, exactly one more translation request is issued.
- R7: If the retried request also completes with `xlDoneOk`=0, the requester receives `rspValid`=1 with `rspErr`=1. Nothing is stored, so a later lookup of that page misses again. `rspErr` is never high without `rspValid`.
- R8: A pulse on `invValid` with `invAll`=0 clears only the entry whose identifier and page both equal `invSpace`/`invPage`. An entry with the same page but a different identifier keeps hitting.
- R9: A pulse on `invValid` with `invAll`=1 clears every entry.
- R10: A fill goes into the lowest-numbered invalid entry if one exists. Otherwise it replaces entries in round-robin order, starting at entry 0 after reset. The pointer advances by one only on a replacement of a valid entry.
- R11: After reset, `lkReady`=1, `rspValid`=0, `xlReqValid`=0, `pgReqValid`=0, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkReady | output | 1 | Lookup accepted on this edge when high |
| lkSpace | input | 20 | Address-space identifier of the lookup |
| lkAddr | input | 48 | Untranslated byte address |
| rspValid | output | 1 | Lookup result present |
| rspErr | output | 1 | 1 = translation failed after retry |
| rspAddr | output | 48 | Translated byte address |
| xlReqValid | output | 1 | Translation request present |
| xlReqReady | input | 1 | Translation request taken |
| xlReqSpace | output | 20 | Identifier of the request |
| xlReqPage | output | 36 | Untranslated page number of the request |
| xlDoneValid | input | 1 | Translation completion pulse |
| xlDoneOk | input | 1 | 1 = translation succeeded |
| xlDonePage | input | 36 | Translated page number |
| pgReqValid | output | 1 | Page request present |
| pgReqReady | input | 1 | Page request taken |
| pgReqSpace | output | 20 | Identifier of the page request |
| pgReqPage | output | 36 | Page number of the page request |
| pgPresent | input | 1 | Page now resident, retry allowed |
| invValid | input | 1 | Invalidate command pulse |
| invAll | input | 1 | 1 = clear every entry |
| invSpace | input | 20 | Identifier to invalidate |
| invPage | input | 36 | Page number to invalidate |

## Verification
The bench fills all eight entries and then forces replacements. It checks that the victim is entry 0, then entry 1, and that a slot freed by invalidation is used before the pointer's slot. A design with a wrong victim choice would hit on an evicted page or miss on a kept page. The bench also looks up the same page under two identifiers and sends an invalidation whose identifier does not match. A design that compares the page alone would give a hit where a miss is expected, or lose an entry it should keep. The fault path is driven with one failure and then with two. This catches a design that retries without waiting for the page-present pulse, retries more than once, or caches the failed result.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned SPACE_W = 20;
  localparam int unsigned PAGE_W  = 36;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned NUM_ENT = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch lookup, sample hit result
    logic fill;     // write completion into victim entry
  } xlatStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_XL,
    ST_WAIT_XL,
    ST_SEND_PG,
    ST_WAIT_PG
  } ctrlState_t;
endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES  = NUM_ENT,
  parameter int unsigned SPACE_WD = SPACE_W,
  parameter int unsigned PAGE_WD  = PAGE_W,
  parameter int unsigned OFF_WD   = OFF_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  xlatStrobe_t                strobe,
  input  logic [SPACE_WD-1:0]        lkSpace,
  input  logic [PAGE_WD+OFF_WD-1:0]  lkAddr,
  input  logic [PAGE_WD-1:0]         xlDonePage,
  input  logic                       invValid,
  input  logic                       invAll,
  input  logic [SPACE_WD-1:0]        invSpace,
  input  logic [PAGE_WD-1:0]         invPage,
  output logic                       lkHit,
  output logic [SPACE_WD-1:0]        reqSpace,
  output logic [PAGE_WD-1:0]         reqPage,
  output logic [PAGE_WD+OFF_WD-1:0]  rspAddr
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned ADDR_W = PAGE_WD + OFF_WD;

  logic [ENTRIES-1:0]  entValid;
  logic [SPACE_WD-1:0] entSpace [ENTRIES];
  logic [PAGE_WD-1:0]  entPage  [ENTRIES];
  logic [PAGE_WD-1:0]  entXlat  [ENTRIES];

  logic [ENTRIES-1:0]  hitVec;
  logic [ENTRIES-1:0]  invVec;
  logic [PAGE_WD-1:0]  lkPage;
  logic [PAGE_WD-1:0]  hitXlat;
  logic [IDX_W-1:0]    rrPtr;
  logic [IDX_W-1:0]    victimIdx;
  logic                allValid;
  logic [OFF_WD-1:0]   reqOff;
  logic [PAGE_WD-1:0]  rspPageQ;

  assign lkPage = lkAddr[ADDR_W-1:OFF_WD];

  // per-entry tag compare for lookup and invalidate
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign hitVec[gi] = entValid[gi] && (entSpace[gi] == lkSpace)
                        && (entPage[gi] == lkPage);
    assign invVec[gi] = entValid[gi] && (entSpace[gi] == invSpace)
                        && (entPage[gi] == invPage);
  end

  assign lkHit = |hitVec;

  always_comb begin
    hitXlat = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitXlat = hitXlat | entXlat[i];
    end
  end

  // victim: lowest invalid slot, else round-robin pointer
  always_comb begin
    logic found;
    found     = 1'b0;
    victimIdx = rrPtr;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!entValid[i] && !found) begin
        victimIdx = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign allValid = &entValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (invValid && (invAll || invVec[i])) entValid[i] <= 1'b0;
        if (strobe.fill && (victimIdx == IDX_W'(i))) entValid[i] <= 1'b1;
      end
      if (strobe.fill && allValid) begin
        rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobe.fill && (victimIdx == IDX_W'(i))) begin
        entSpace[i] <= reqSpace;
        entPage[i]  <= reqPage;
        entXlat[i]  <= xlDonePage;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqSpace <= '0;
      reqPage  <= '0;
      reqOff   <= '0;
      rspPageQ <= '0;
    end else begin
      if (strobe.capture) begin
        reqSpace <= lkSpace;
        reqPage  <= lkPage;
        reqOff   <= lkAddr[OFF_WD-1:0];
        rspPageQ <= hitXlat;
      end
      if (strobe.fill) rspPageQ <= xlDonePage;
    end
  end

  assign rspAddr = {rspPageQ, reqOff};
endmodule

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lkValid,
  input  logic        lkHit,
  output logic        lkReady,
  output logic        xlReqValid,
  input  logic        xlReqReady,
  input  logic        xlDoneValid,
  input  logic        xlDoneOk,
  output logic        pgReqValid,
  input  logic        pgReqReady,
  input  logic        pgPresent,
  output logic        rspValid,
  output logic        rspErr,
  output xlatStrobe_t strobe
);
  ctrlState_t state;
  logic       retried;

  assign lkReady        = (state == ST_IDLE);
  assign xlReqValid     = (state == ST_SEND_XL);
  assign pgReqValid     = (state == ST_SEND_PG);
  assign strobe.capture = lkReady && lkValid;
  assign strobe.fill    = (state == ST_WAIT_XL) && xlDoneValid && xlDoneOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retried  <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (lkValid) begin
            if (lkHit) begin
              rspValid <= 1'b1;
            end else begin
              state   <= ST_SEND_XL;
              retried <= 1'b0;
            end
          end
        end
        ST_SEND_XL: begin
          if (xlReqReady) state <= ST_WAIT_XL;
        end
        ST_WAIT_XL: begin
          if (xlDoneValid) begin
            if (xlDoneOk) begin
              rspValid <= 1'b1;
              state    <= ST_IDLE;
            end else if (!retried) begin
              state <= ST_SEND_PG;
            end else begin
              rspValid <= 1'b1;
              rspErr   <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        ST_SEND_PG: begin
          if (pgReqReady) state <= ST_WAIT_PG;
        end
        ST_WAIT_PG: begin
          if (pgPresent) begin
            state   <= ST_SEND_XL;
            retried <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlat_cache.sv
module dma_xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES  = NUM_ENT,
  parameter int unsigned SPACE_WD = SPACE_W,
  parameter int unsigned PAGE_WD  = PAGE_W,
  parameter int unsigned OFF_WD   = OFF_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lkValid,
  output logic                      lkReady,
  input  logic [SPACE_WD-1:0]       lkSpace,
  input  logic [PAGE_WD+OFF_WD-1:0] lkAddr,
  output logic                      rspValid,
  output logic                      rspErr,
  output logic [PAGE_WD+OFF_WD-1:0] rspAddr,
  output logic                      xlReqValid,
  input  logic                      xlReqReady,
  output logic [SPACE_WD-1:0]       xlReqSpace,
  output logic [PAGE_WD-1:0]        xlReqPage,
  input  logic                      xlDoneValid,
  input  logic                      xlDoneOk,
  input  logic [PAGE_WD-1:0]        xlDonePage,
  output logic                      pgReqValid,
  input  logic                      pgReqReady,
  output logic [SPACE_WD-1:0]       pgReqSpace,
  output logic [PAGE_WD-1:0]        pgReqPage,
  input  logic                      pgPresent,
  input  logic                      invValid,
  input  logic                      invAll,
  input  logic [SPACE_WD-1:0]       invSpace,
  input  logic [PAGE_WD-1:0]        invPage
);
  xlatStrobe_t         strobe;
  logic                lkHit;
  logic [SPACE_WD-1:0] reqSpace;
  logic [PAGE_WD-1:0]  reqPage;

  xlat_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lkValid    (lkValid),
    .lkHit      (lkHit),
    .lkReady    (lkReady),
    .xlReqValid (xlReqValid),
    .xlReqReady (xlReqReady),
    .xlDoneValid(xlDoneValid),
    .xlDoneOk   (xlDoneOk),
    .pgReqValid (pgReqValid),
    .pgReqReady (pgReqReady),
    .pgPresent  (pgPresent),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .strobe     (strobe)
  );

  xlat_datapath #(
    .ENTRIES (ENTRIES),
    .SPACE_WD(SPACE_WD),
    .PAGE_WD (PAGE_WD),
    .OFF_WD  (OFF_WD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lkSpace   (lkSpace),
    .lkAddr    (lkAddr),
    .xlDonePage(xlDonePage),
    .invValid  (invValid),
    .invAll    (invAll),
    .invSpace  (invSpace),
    .invPage   (invPage),
    .lkHit     (lkHit),
    .reqSpace  (reqSpace),
    .reqPage   (reqPage),
    .rspAddr   (rspAddr)
  );

  assign xlReqSpace = reqSpace;
  assign xlReqPage  = reqPage;
  assign pgReqSpace = reqSpace;
  assign pgReqPage  = reqPage;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
  import xlat_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               lkReady,
  input logic               hitNow,
  input logic               rspValid,
  input logic               rspErr,
  input logic               xlReqValid,
  input logic               xlReqReady,
  input logic [SPACE_W-1:0] xlReqSpace,
  input logic [PAGE_W-1:0]  xlReqPage,
  input logic               pgReqValid,
  input logic               pgReqReady,
  input logic [SPACE_W-1:0] pgReqSpace,
  input logic [PAGE_W-1:0]  pgReqPage
);
  // R1
  one_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlReqValid || pgReqValid) |-> !lkReady);

  // R1
  miss_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady && !hitNow) |=> !rspValid);

  // R2
  xl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlReqValid && !xlReqReady) |=>
      (xlReqValid && $stable(xlReqSpace) && $stable(xlReqPage)));

  // R4
  hit_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady && hitNow) |=> (rspValid && !rspErr));

  // R6
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgReqValid && !pgReqReady) |=>
      (pgReqValid && $stable(pgReqSpace) && $stable(pgReqPage)));

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(xlReqValid && pgReqValid));

  // R7
  err_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);
endmodule

bind dma_xlat_cache xlat_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lkValid   (lkValid),
  .lkReady   (lkReady),
  .hitNow    (lkHit),
  .rspValid  (rspValid),
  .rspErr    (rspErr),
  .xlReqValid(xlReqValid),
  .xlReqReady(xlReqReady),
  .xlReqSpace(xlReqSpace),
  .xlReqPage (xlReqPage),
  .pgReqValid(pgReqValid),
  .pgReqReady(pgReqReady),
  .pgReqSpace(pgReqSpace),
  .pgReqPage (pgReqPage)
);

// File: tb/dma_xlat_cache_bench.sv
module dma_xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lkValid;
  logic        lkReady;
  logic [19:0] lkSpace;
  logic [47:0] lkAddr;
  logic        rspValid, rspErr;
  logic [47:0] rspAddr;
  logic        xlReqValid, xlReqReady;
  logic [19:0] xlReqSpace;
  logic [35:0] xlReqPage;
  logic        xlDoneValid, xlDoneOk;
  logic [35:0] xlDonePage;
  logic        pgReqValid, pgReqReady;
  logic [19:0] pgReqSpace;
  logic [35:0] pgReqPage;
  logic        pgPresent;
  logic        invValid, invAll;
  logic [19:0] invSpace;
  logic [35:0] invPage;

  always #5 clk = ~clk;

  dma_xlat_cache u_dma_xlat_cache (.*);

  int checks = 0;
  int errors = 0;
  int xlCount = 0;
  int pgCount = 0;
  int faultLeft = 0;
  logic [19:0] expSpace;
  logic [35:0] expPage;
  bit done = 1'b0;

  // scoreboard queues
  bit          qErr [$];
  logic [47:0] qAddr[$];
  string       qTag [$];

  function automatic logic [35:0] xl(input logic [19:0] s, input logic [35:0] p);
    return p ^ {16'hA5C3, s} ^ 36'h7_0000_0000;
  endfunction

  task automatic chk(input bit ok, input string msg,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // monitor: pops expected results as responses appear
  always @(negedge clk) begin
    if (rstN === 1'b1 && rspValid === 1'b1) begin
      if (qErr.size() == 0) begin
        chk(1'b0, "R4 unexpected response", 64'(rspAddr), 64'h0);
      end else begin
        bit          e;
        logic [47:0] a;
        string       t;
        e = qErr.pop_front();
        a = qAddr.pop_front();
        t = qTag.pop_front();
        chk(rspErr == e, {t, " rspErr"}, 64'(rspErr), 64'(e));
        if (!e) chk(rspAddr == a, {t, " rspAddr"}, 64'(rspAddr), 64'(a));
      end
    end
  end

  // host-side responder for translation and page requests
  initial begin
    xlReqReady = 0; xlDoneValid = 0; xlDoneOk = 0; xlDonePage = '0;
    pgReqReady = 0; pgPresent = 0;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && xlReqValid === 1'b1) begin
        chk(xlReqSpace == expSpace, "R1 request space", 64'(xlReqSpace), 64'(expSpace));
        chk(xlReqPage == expPage, "R1 request page", 64'(xlReqPage), 64'(expPage));
        @(negedge clk);
        chk(xlReqValid && xlReqPage == expPage, "R2 request held", 64'(xlReqPage), 64'(expPage));
        xlReqReady = 1;
        @(negedge clk);
        xlReqReady = 0;
        xlCount++;
        @(negedge clk);
        @(negedge clk);
        xlDoneValid = 1;
        xlDoneOk    = (faultLeft == 0);
        xlDonePage  = xl(expSpace, expPage);
        if (faultLeft > 0) faultLeft--;
        @(negedge clk);
        xlDoneValid = 0;
      end else if (rstN === 1'b1 && pgReqValid === 1'b1) begin
        chk(pgReqSpace == expSpace && pgReqPage == expPage, "R6 page request",
            64'(pgReqPage), 64'(expPage));
        pgReqReady = 1;
        @(negedge clk);
        pgReqReady = 0;
        pgCount++;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(!xlReqValid, "R6 no retry before page present", 64'(xlReqValid), 64'h0);
        end
        pgPresent = 1;
        @(negedge clk);
        pgPresent = 0;
      end
    end
  end

  task automatic lookup(input logic [19:0] s, input logic [35:0] p,
                        input logic [11:0] off, input bit expHit, input bit expErr,
                        input int expXl, input int expPg, input string tag);
    int x0, p0;
    x0 = xlCount;
    p0 = pgCount;
    expSpace = s;
    expPage  = p;
    qErr.push_back(expErr);
    qAddr.push_back({xl(s, p), off});
    qTag.push_back(tag);
    @(negedge clk);
    lkValid = 1; lkSpace = s; lkAddr = {p, off};
    while (!lkReady) @(negedge clk);
    @(negedge clk);
    lkValid = 0;
    if (expHit) chk(rspValid === 1'b1, {tag, " hit latency"}, 64'(rspValid), 64'h1);
    else        chk(rspValid === 1'b0, {tag, " miss no early response"}, 64'(rspValid), 64'h0);
    while (qErr.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(xlCount - x0 == expXl, {tag, " translation requests"}, 64'(xlCount - x0), 64'(expXl));
    chk(pgCount - p0 == expPg, {tag, " page requests"}, 64'(pgCount - p0), 64'(expPg));
  endtask

  task automatic invalidate(input bit all, input logic [19:0] s, input logic [35:0] p);
    @(negedge clk);
    invValid = 1; invAll = all; invSpace = s; invPage = p;
    @(negedge clk);
    invValid = 0; invAll = 0;
  endtask

  localparam logic [19:0] SA = 20'h00042;
  localparam logic [19:0] SB = 20'h00077;

  initial begin
    rstN = 0; lkValid = 0; lkSpace = '0; lkAddr = '0;
    invValid = 0; invAll = 0; invSpace = '0; invPage = '0;
    expSpace = '0; expPage = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk(lkReady === 1'b1, "R11 lkReady", 64'(lkReady), 64'h1);
    chk(rspValid === 1'b0, "R11 rspValid", 64'(rspValid), 64'h0);
    chk(xlReqValid === 1'b0, "R11 xlReqValid", 64'(xlReqValid), 64'h0);
    chk(pgReqValid === 1'b0, "R11 pgReqValid", 64'(pgReqValid), 64'h0);

    lookup(SA, 36'h100, 12'h123, 0, 0, 1, 0, "R3");   // slot 0; R11 empty
    lookup(SA, 36'h100, 12'hABC, 1, 0, 0, 0, "R4");
    lookup(SB, 36'h100, 12'h004, 0, 0, 1, 0, "R5");   // slot 1
    lookup(SA, 36'h100, 12'h008, 1, 0, 0, 0, "R5");
    for (int i = 1; i <= 6; i++)                      // slots 2..7
      lookup(SA, 36'h100 + 36'(i), 12'h010, 0, 0, 1, 0, "R3");
    lookup(SA, 36'h200, 12'h020, 0, 0, 1, 0, "R10"); // evicts slot 0
    lookup(SA, 36'h100, 12'h030, 0, 0, 1, 0, "R10"); // evicts slot 1
    lookup(SB, 36'h100, 12'h040, 0, 0, 1, 0, "R10"); // evicts slot 2
    lookup(SA, 36'h102, 12'h050, 1, 0, 0, 0, "R10");
    invalidate(0, SB, 36'h104);
    lookup(SA, 36'h104, 12'h060, 1, 0, 0, 0, "R8");
    invalidate(0, SA, 36'h104);
    lookup(SA, 36'h104, 12'h070, 0, 0, 1, 0, "R8");  // refills free slot 5
    lookup(SA, 36'h102, 12'h080, 1, 0, 0, 0, "R10"); // slot 3 kept
    faultLeft = 1;
    lookup(SA, 36'h300, 12'h090, 0, 0, 2, 1, "R6");
    faultLeft = 2;
    lookup(SA, 36'h400, 12'h0A0, 0, 1, 2, 1, "R7");
    lookup(SA, 36'h400, 12'h0B0, 0, 0, 1, 0, "R7");
    invalidate(1, '0, '0);
    lookup(SA, 36'h200, 12'h0C0, 0, 0, 1, 0, "R9");
    lookup(SB, 36'h100, 12'h0D0, 0, 0, 1, 0, "R9");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule